// File: doc/BRIEF.md
# SIMD Floating-Point Issue Interlock

This block sits in front of an in-order SIMD floating-point pipeline. Each cycle it decides whether the instruction at its input may issue or must wait. An instruction is described by an operation class, a register format, up to three source registers and a destination register. The block drives a beat-issue strobe, a stall flag and a ready signal that completes a valid/ready handshake on the whole instruction. It models only interlock timing. It contains no arithmetic, no register file and no writeback.

A per-register scoreboard tracks 32 registers of 64 bits. Each entry is a countdown of the cycles until the register's pending result can be forwarded. Entries written by multiply-accumulate operations are tagged, so that consumers of those results wait out the full accumulate chain. A separate ordering counter holds back independent adds and multiplies behind a multiply-accumulate, which keeps retirement in order. A 128-bit operation issues as two beats, low half first, and each beat is checked against its own halves of the registers.

Top module: `simdIssueInterlock`

## Requirements
- R1: With `inQuad`=1, an operation issues as two beats. The first beat is the low half (`issueHigh`=0) and uses D registers 2n. The second beat is the high half (`issueHigh`=1) and uses D registers 2n+1, where n is the low four bits of a register field. `inReady` rises only with the second beat. A 64-bit operation issues in a single beat.
- R2: At most one beat issues per cycle. `issue` is never high without `inValid`. `stall` is high exactly when `inValid` is high and no beat issues.
- R3: Add/compare (class 0), multiply (class 1) and unary (class 2) operations read their sources at stage 2 and produce results at stage 5. A dependent operation issued right after its producer therefore stalls 2 cycles.
- R4: Pairwise operations (class 3) read both sources at stage 1, so a dependent pairwise operation stalls 3 cycles. A pairwise operation always issues as one beat, whatever `inQuad` says. Scalar-by-element multiplies (class 4) read `inSrcB` at stage 1; this field is always a D register number. They read `inSrcA` at stage 2.
- R5: Multiply-accumulate (class 5) reads its accumulator `inSrcAcc` at stage 3 and its multiplicands at stage 2. Multiply-accumulate and reciprocal step (class 6) produce results at stage 9. A dependent operation right after a step operation stalls 6 cycles.
- R6: A multiply-accumulate that follows a multiply-accumulate with no dependence on it issues without stall.
- R7: For 4 cycles after a multiply-accumulate beat issues, no add/compare or multiply may issue, even when it is independent. Unary operations are not held back by this rule.
- R8: Any operation that reads a register written by a multiply-accumulate waits 8 cycles after that beat issues.
- R9: A cycle with `flush`=1 issues nothing. It clears every scoreboard entry and the ordering counter, and it returns the beat sequencer to the low half.
- R10: After reset every register is ready, no beat is pending, and `issue`, `inReady` and `stall` are low while `inValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all interlock state |
| inValid | input | 1 | Instruction descriptor valid |
| inClass | input | 3 | Operation class: 0 add/compare, 1 multiply, 2 unary, 3 pairwise, 4 scalar multiply, 5 multiply-accumulate, 6 reciprocal step |
| inQuad | input | 1 | 1 = 128-bit format, 0 = 64-bit format |
| inSrcA | input | 5 | First source register |
| inSrcB | input | 5 | Second source register (scalar element register for class 4) |
| inSrcAcc | input | 5 | Accumulator register (class 5 only) |
| inDst | input | 5 | Destination register |
| inReady | output | 1 | Instruction accepted this cycle (last beat issues) |
| issue | output | 1 | A beat issues this cycle |
| issueHigh | output | 1 | The pending beat is the high half |
| stall | output | 1 | Valid instruction held this cycle |

## Verification
A dependence stall and the ordering hold behind a multiply-accumulate can apply to the same add in the same cycles. The bench provokes this with a multiply-accumulate followed by an add that reads its result, and expects the longer 8-cycle wait rather than the 4-cycle one or the sum of both. A second overlap comes from a 128-bit multiply-accumulate followed by a 64-bit add. The high beat re-arms the ordering counter while the low beat's result has already aged a cycle, so the bench expects 4 cycles for an independent add, 8 for a read of the high half and 7 for a read of the low half.

// File: rtl/simdIlkPkg.sv
package simdIlkPkg;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_MUL    = 3'd1,
    OP_UNARY  = 3'd2,
    OP_PAIR   = 3'd3,
    OP_SCALAR = 3'd4,
    OP_MAC    = 3'd5,
    OP_STEP   = 3'd6,
    OP_RSVD   = 3'd7
  } opClass_e;

  localparam int STG_W = 4;

  // pipeline stage numbers used by the interlock
  localparam logic [STG_W-1:0] NEED_EARLY = 4'd1;
  localparam logic [STG_W-1:0] NEED_NORM  = 4'd2;
  localparam logic [STG_W-1:0] NEED_ACC   = 4'd3;
  localparam logic [STG_W-1:0] RES_SHORT  = 4'd5;
  localparam logic [STG_W-1:0] RES_LONG   = 4'd9;

  typedef struct packed {
    logic issue;
    logic markMac;
    logic flush;
  } sbStrobe_t;

endpackage

// File: rtl/simdIlkScbd.sv
module simdIlkScbd
  import simdIlkPkg::*;
#(
  parameter int NUM_DREGS = 32,
  parameter int AW        = $clog2(NUM_DREGS),
  parameter int GAP_CYC   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sbStrobe_t                  strobe,
  input  logic [AW-1:0]              dstAddr,
  input  logic [STG_W-1:0]           dstLat,
  input  logic [2:0][AW-1:0]         qAddr,
  input  logic [2:0][STG_W-1:0]      qNeed,
  input  logic [2:0]                 qUse,
  output logic [2:0]                 srcBlock,
  output logic                       orderBlock
);

  localparam int GW = $clog2(GAP_CYC + 1);

  logic [STG_W-1:0] rem    [NUM_DREGS];
  logic             macTag [NUM_DREGS];
  logic [NUM_DREGS-1:0] busyVec;
  logic [GW-1:0]    gap;

  // one countdown entry per D register
  for (genvar g = 0; g < NUM_DREGS; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rem[g]    <= '0;
        macTag[g] <= 1'b0;
      end else if (strobe.flush) begin
        rem[g]    <= '0;
        macTag[g] <= 1'b0;
      end else if (strobe.issue && dstAddr == AW'(g)) begin
        rem[g]    <= dstLat - 1'b1;
        macTag[g] <= strobe.markMac;
      end else if (rem[g] != '0) begin
        rem[g]    <= rem[g] - 1'b1;
      end
    end
    assign busyVec[g] = (rem[g] != '0);
  end

  // hazard query for the three possible source operands
  always_comb begin
    for (int k = 0; k < 3; k++) begin
      if (macTag[qAddr[k]])
        srcBlock[k] = qUse[k] && (rem[qAddr[k]] != '0);
      else
        srcBlock[k] = qUse[k] && (rem[qAddr[k]] > qNeed[k]);
    end
  end

  // ordering counter armed by multiply-accumulate beats
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gap <= '0;
    else if (strobe.flush)
      gap <= '0;
    else if (strobe.issue && strobe.markMac)
      gap <= GW'(GAP_CYC);
    else if (gap != '0)
      gap <= gap - 1'b1;
  end

  assign orderBlock = (gap != '0);

  assert_gap_armed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.markMac && !strobe.flush) |=> orderBlock);

  assert_mac_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.markMac && !strobe.flush) |=>
      (macTag[$past(dstAddr)] && rem[$past(dstAddr)] == RES_LONG - 1'b1));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (busyVec == '0 && !orderBlock));

endmodule

// File: rtl/simdIlkCtrl.sv
module simdIlkCtrl
  import simdIlkPkg::*;
#(
  parameter int AW = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic                  inValid,
  input  logic [2:0]            inClass,
  input  logic                  inQuad,
  input  logic [AW-1:0]         inSrcA,
  input  logic [AW-1:0]         inSrcB,
  input  logic [AW-1:0]         inSrcAcc,
  input  logic [AW-1:0]         inDst,
  input  logic [2:0]            srcBlock,
  input  logic                  orderBlock,
  output logic [2:0][AW-1:0]    qAddr,
  output logic [2:0][STG_W-1:0] qNeed,
  output logic [2:0]            qUse,
  output logic [AW-1:0]         dstAddr,
  output logic [STG_W-1:0]      dstLat,
  output sbStrobe_t             strobe,
  output logic                  inReady,
  output logic                  issue,
  output logic                  issueHigh,
  output logic                  stall
);

  opClass_e cls;
  logic     isQuad;
  logic     hiPending;
  logic     addMul;

  function automatic logic [AW-1:0] mapReg(input logic [AW-1:0] f,
                                           input logic quad,
                                           input logic high);
    return quad ? {f[AW-2:0], high} : f;
  endfunction

  always_comb begin
    cls    = opClass_e'(inClass);
    isQuad = inQuad && (cls != OP_PAIR);
    addMul = (cls == OP_ADD) || (cls == OP_MUL);

    qAddr[0] = mapReg(inSrcA, isQuad, hiPending);
    qAddr[1] = (cls == OP_SCALAR) ? inSrcB : mapReg(inSrcB, isQuad, hiPending);
    qAddr[2] = mapReg(inSrcAcc, isQuad, hiPending);
    dstAddr  = mapReg(inDst, isQuad, hiPending);

    qUse[0] = 1'b1;
    qUse[1] = (cls != OP_UNARY) && (cls != OP_RSVD);
    qUse[2] = (cls == OP_MAC);

    qNeed[0] = (cls == OP_PAIR) ? NEED_EARLY : NEED_NORM;
    qNeed[1] = (cls == OP_PAIR || cls == OP_SCALAR) ? NEED_EARLY : NEED_NORM;
    qNeed[2] = NEED_ACC;

    dstLat = (cls == OP_MAC || cls == OP_STEP) ? RES_LONG : RES_SHORT;

    issue   = inValid && !flush && (srcBlock == '0) && !(orderBlock && addMul);
    inReady = issue && (!isQuad || hiPending);
    stall   = inValid && !issue;

    strobe.issue   = issue;
    strobe.markMac = (cls == OP_MAC);
    strobe.flush   = flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      hiPending <= 1'b0;
    else if (flush)
      hiPending <= 1'b0;
    else if (issue && isQuad)
      hiPending <= !hiPending;
  end

  assign issueHigh = hiPending;

  assert_low_then_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !inReady && !flush) |=> issueHigh);

  assert_high_completes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (issue && issueHigh) |-> inReady);

  assert_gap_holds_addmul_R7: assert property (@(posedge clk) disable iff (!rstN)
    (orderBlock && addMul) |-> !issue);

endmodule

// File: rtl/simdIssueInterlock.sv
module simdIssueInterlock
  import simdIlkPkg::*;
#(
  parameter int NUM_DREGS = 32,
  parameter int GAP_CYC   = 4,
  localparam int AW       = $clog2(NUM_DREGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          inValid,
  input  logic [2:0]    inClass,
  input  logic          inQuad,
  input  logic [AW-1:0] inSrcA,
  input  logic [AW-1:0] inSrcB,
  input  logic [AW-1:0] inSrcAcc,
  input  logic [AW-1:0] inDst,
  output logic          inReady,
  output logic          issue,
  output logic          issueHigh,
  output logic          stall
);

  logic [2:0][AW-1:0]    qAddr;
  logic [2:0][STG_W-1:0] qNeed;
  logic [2:0]            qUse;
  logic [2:0]            srcBlock;
  logic                  orderBlock;
  logic [AW-1:0]         dstAddr;
  logic [STG_W-1:0]      dstLat;
  sbStrobe_t             strobe;

  simdIlkCtrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .inValid(inValid), .inClass(inClass), .inQuad(inQuad),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inSrcAcc(inSrcAcc), .inDst(inDst),
    .srcBlock(srcBlock), .orderBlock(orderBlock),
    .qAddr(qAddr), .qNeed(qNeed), .qUse(qUse),
    .dstAddr(dstAddr), .dstLat(dstLat), .strobe(strobe),
    .inReady(inReady), .issue(issue), .issueHigh(issueHigh), .stall(stall)
  );

  simdIlkScbd #(.NUM_DREGS(NUM_DREGS), .AW(AW), .GAP_CYC(GAP_CYC)) uScbd (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dstAddr(dstAddr), .dstLat(dstLat),
    .qAddr(qAddr), .qNeed(qNeed), .qUse(qUse),
    .srcBlock(srcBlock), .orderBlock(orderBlock)
  );

endmodule

// File: tb/tb_simdIssueInterlock.sv
`timescale 1ns/1ps
module tb_simdIssueInterlock;

  localparam int C_ADD = 0, C_MUL = 1, C_UNA = 2, C_PAIR = 3,
                 C_SCL = 4, C_MAC = 5, C_STEP = 6;
  localparam int NV = 21;
  // producer: cls,q,a,b,acc,dst | consumer: cls,q,a,b,acc,dst | stalls, beats, req
  localparam int VECS [NV][15] = '{
    '{C_ADD,0,1,2,0,4,  C_ADD,0,4,3,0,10,    2,1,3},  // R3
    '{C_ADD,0,1,2,0,4,  C_UNA,0,4,0,0,10,    2,1,3},  // R3
    '{C_ADD,0,1,2,0,4,  C_PAIR,0,4,3,0,10,   3,1,4},  // R4
    '{C_ADD,0,1,2,0,4,  C_SCL,0,1,4,0,10,    3,1,4},  // R4
    '{C_ADD,0,1,2,0,4,  C_SCL,0,4,9,0,10,    2,1,4},  // R4
    '{C_MUL,0,1,2,0,4,  C_MAC,0,1,2,4,11,    1,1,5},  // R5
    '{C_MUL,0,1,2,0,4,  C_MAC,0,4,2,3,11,    2,1,5},  // R5
    '{C_STEP,0,1,2,0,6, C_ADD,0,6,2,0,11,    6,1,5},  // R5
    '{C_MAC,0,1,2,3,6,  C_MAC,0,8,9,10,11,   0,1,6},  // R6
    '{C_MAC,0,1,2,3,6,  C_ADD,0,8,9,0,11,    4,1,7},  // R7
    '{C_MAC,0,1,2,3,6,  C_MUL,0,8,9,0,11,    4,1,7},  // R7
    '{C_MAC,0,1,2,3,6,  C_UNA,0,8,0,0,11,    0,1,7},  // R7
    '{C_MAC,0,1,2,3,6,  C_UNA,0,6,0,0,11,    8,1,8},  // R8
    '{C_MAC,0,1,2,3,6,  C_MAC,0,8,9,6,11,    8,1,8},  // R8
    '{C_MAC,0,1,2,3,6,  C_ADD,0,6,9,0,11,    8,1,8},  // R8
    '{C_ADD,1,0,1,0,2,  C_ADD,0,5,12,0,20,   2,1,1},  // R1 high half
    '{C_ADD,1,0,1,0,2,  C_ADD,0,4,12,0,20,   1,1,1},  // R1 low half
    '{C_ADD,0,1,2,0,5,  C_ADD,1,2,3,0,8,     1,2,1},  // R1 consumer quad
    '{C_ADD,0,1,2,0,9,  C_PAIR,1,1,2,0,12,   0,1,4},  // R4 pairwise one beat
    '{C_MAC,1,4,5,6,3,  C_ADD,0,20,21,0,22,  4,1,7},  // R7 quad MAC
    '{C_MAC,1,4,5,6,3,  C_ADD,0,6,21,0,22,   7,1,8}   // R8 low half of quad MAC
  };

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0, inValid = 1'b0, inQuad = 1'b0;
  logic [2:0] inClass = '0;
  logic [4:0] inSrcA = '0, inSrcB = '0, inSrcAcc = '0, inDst = '0;
  logic inReady, issue, issueHigh, stall;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simdIssueInterlock dut (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid),
    .inClass(inClass), .inQuad(inQuad), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .inSrcAcc(inSrcAcc), .inDst(inDst), .inReady(inReady), .issue(issue),
    .issueHigh(issueHigh), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic present(input int c, input int q, input int a, input int b,
                         input int acc, input int d);
    inClass = 3'(c); inQuad = 1'(q); inSrcA = 5'(a); inSrcB = 5'(b);
    inSrcAcc = 5'(acc); inDst = 5'(d); inValid = 1'b1;
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic runInstr(input int c, input int q, input int a, input int b,
                          input int acc, input int d, output int stalls, output int beats);
    stalls = 0; beats = 0;
    present(c, q, a, b, acc, d);
    for (int i = 0; i < 40; i++) begin
      #1;
      if (issue) beats++;
      if (stall) stalls++;
      if (inReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doFlush();
    inValid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int st, bt, ist, ibt;
    // R10: outputs quiet during and after reset
    @(negedge clk); #1;
    check(!issue && !inReady && !stall, "R10 quiet in reset", issue, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    check(!issue && !inReady && !stall, "R10 quiet idle", stall, 0);
    check(!issueHigh, "R10 no pending beat", issueHigh, 0);
    @(negedge clk);
    runInstr(C_ADD, 0, 1, 2, 0, 3, st, bt);
    check(st == 0, "R10 all registers ready", st, 0);

    // table of producer/consumer pairs
    for (int v = 0; v < NV; v++) begin
      doFlush();
      runInstr(VECS[v][0], VECS[v][1], VECS[v][2], VECS[v][3], VECS[v][4], VECS[v][5], ist, ibt);
      runInstr(VECS[v][6], VECS[v][7], VECS[v][8], VECS[v][9], VECS[v][10], VECS[v][11], st, bt);
      check(st == VECS[v][12], $sformatf("R%0d vec%0d stalls", VECS[v][14], v), st, VECS[v][12]);
      check(bt == VECS[v][13], $sformatf("R%0d vec%0d beats", VECS[v][14], v), bt, VECS[v][13]);
    end

    // R1: beat order of a quad operation
    doFlush();
    present(C_ADD, 1, 1, 2, 0, 5);
    #1;
    check(issue && !issueHigh && !inReady, "R1 first beat low", {issue, issueHigh, inReady}, 3'b100);
    @(negedge clk); #1;
    check(issue && issueHigh && inReady, "R1 second beat high", {issue, issueHigh, inReady}, 3'b111);
    @(negedge clk); inValid = 1'b0; #1;
    check(!issueHigh && !stall, "R2 idle after quad", stall, 0);

    // R2: stall flag while held, descriptor stable
    doFlush();
    runInstr(C_ADD, 0, 1, 2, 0, 4, ist, ibt);
    present(C_ADD, 0, 4, 2, 0, 7);
    #1;
    check(stall && !issue, "R2 held instruction stalls", stall, 1);
    @(negedge clk); #1;
    check(stall && !issue, "R2 still held", stall, 1);
    @(negedge clk); #1;
    check(issue && !stall && inReady, "R2 issues when ready", issue, 1);
    @(negedge clk); inValid = 1'b0;

    // R9: flush drops a MAC result dependence and the ordering hold
    doFlush();
    runInstr(C_MAC, 0, 1, 2, 3, 6, ist, ibt);
    doFlush();
    runInstr(C_UNA, 0, 6, 0, 0, 9, st, bt);
    check(st == 0, "R9 flush clears entry", st, 0);
    doFlush();
    runInstr(C_MAC, 0, 1, 2, 3, 6, ist, ibt);
    doFlush();
    runInstr(C_ADD, 0, 8, 9, 0, 10, st, bt);
    check(st == 0, "R9 flush clears ordering hold", st, 0);
    // R9: no issue during flush, beat sequencer reset
    doFlush();
    present(C_ADD, 1, 1, 2, 0, 5);
    #1;
    @(negedge clk); flush = 1'b1; #1;
    check(!issue, "R9 no issue while flushing", issue, 0);
    @(negedge clk); flush = 1'b0; #1;
    check(issue && !issueHigh, "R9 sequencer back to low", issueHigh, 0);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule